// File: doc/BRIEF.md
# Scan-Path Register Bus Bridge

This block lets a debug host reach a bank of 32-bit registers through the boundary-scan port. It sits behind the TAP controller, which supplies the current instruction and single-cycle capture, shift and update strobes for the data path. A 40-bit frame is shifted in LSB first. It carries a data word, a 7-bit register address and a write flag. On the update strobe the bridge starts exactly one access on a simple request/acknowledge bus.

Reads are pipelined. A scan that requests a read only sends the address. The returned word is held and shifts out during the next scan. A host therefore ends every read sequence with one extra scan to collect the final value. That scan should address register 0, the identification word, so that no register with read side effects is touched twice. Before any of this works, the host must set a 5-bit chain number of 0 using the chain-select instruction (0x2) and then load the access instruction (0xC).

Top module: `scan_reg_bridge`

## Requirements
- R1: After reset the chain number is invalid (all ones), the read holding word is 0, no bus request is raised, and a scan under instruction 0xC returns all zeros and starts no access.
- R2: With instruction 0x2, a capture/shift/update sequence loads a 5-bit chain number shifted LSB first. The 40-bit frame is in the scan path only while the instruction is 0xC and the chain number is 0. Otherwise update starts no access.
- R3: The frame is shifted LSB first. Bits 31:0 are data, bits 38:32 are the register address, and bit 39 is the write flag (1 = write). An update with bit 39 set performs one bus write of that data to that address.
- R4: An update with bit 39 clear performs one bus read. The word returned with the acknowledge appears on bits 31:0 of the next scan's output, and bits 39:32 of that output are 0.
- R5: A bus write leaves the read holding word unchanged, so the scan after a write still returns the last read result.
- R6: The request stays high until acknowledged, and address, direction and write data stay stable for the whole request.
- R7: An update that arrives while an access is still outstanding is dropped and starts no access.
- R8: Under any instruction other than 0x2 or 0xC, the serial output is 0 and no access is started.
- R9: A burst of N reads of address 4, issued as one request scan followed by N collecting scans (the last of which addresses register 0), returns each of the N values once and reads address 4 exactly N times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset |
| ir | input | 4 | Current instruction from the TAP |
| capture_dr | input | 1 | Capture strobe for the data path |
| shift_dr | input | 1 | Shift enable for the data path |
| update_dr | input | 1 | Update strobe for the data path |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the selected shift register) |
| bus_req | output | 1 | Access request, held until acknowledged |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with the acknowledge |
| bus_ack | input | 1 | One-cycle access acknowledge |

## Verification
The hardest case to reach from the ports is an update strobe that arrives while the previous access is still waiting for its acknowledge. A full 40-bit scan takes about 43 clocks, so a prompt bus never lets this happen. The bench therefore slows its bus model to acknowledge only after 60 cycles and issues two write scans back to back. It then checks that only the first write reached the register model and that the request was still pending when the second update arrived. The pipelined burst is also exercised with a register whose value changes on each read, so any read duplicated or skipped would show in the collected values and in the pop count.

// File: rtl/scan_reg_bridge.sv
module scan_reg_bridge #(
  parameter int IR_W    = 4,
  parameter int CHAIN_W = 5,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32,
  parameter logic [IR_W-1:0]    SEL_IR    = 'h2,
  parameter logic [IR_W-1:0]    ACC_IR    = 'hC,
  parameter logic [CHAIN_W-1:0] CHAIN_ID  = '0,
  parameter logic [CHAIN_W-1:0] CHAIN_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  localparam int FRAME_W = DATA_W + ADDR_W + 1;
  localparam int PAD_W   = FRAME_W - DATA_W;

  logic [CHAIN_W-1:0] chain_q, csel_sh;
  logic [FRAME_W-1:0] sh_q;
  logic [DATA_W-1:0]  hold_q;

  wire sel_scan = (ir == SEL_IR);
  wire acc_scan = (ir == ACC_IR) && (chain_q == CHAIN_ID);

  assign tdo = sel_scan ? csel_sh[0] : (acc_scan ? sh_q[0] : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_sh <= '0;
      chain_q <= CHAIN_RST;
    end else if (sel_scan) begin
      if (capture_dr)     csel_sh <= '0;
      else if (shift_dr)  csel_sh <= {tdi, csel_sh[CHAIN_W-1:1]};
      else if (update_dr) chain_q <= csel_sh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    sh_q <= '0;
    else if (acc_scan && capture_dr) sh_q <= {{PAD_W{1'b0}}, hold_q};
    else if (acc_scan && shift_dr)   sh_q <= {tdi, sh_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      hold_q    <= '0;
    end else if (bus_req) begin
      if (bus_ack) begin
        bus_req <= 1'b0;
        if (!bus_we) hold_q <= bus_rdata;
      end
    end else if (acc_scan && update_dr) begin
      bus_req   <= 1'b1;
      bus_we    <= sh_q[FRAME_W-1];
      bus_addr  <= sh_q[DATA_W +: ADDR_W];
      bus_wdata <= sh_q[DATA_W-1:0];
    end
  end

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req);

  a_r6_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r2_launch_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(update_dr) && ($past(ir) == ACC_IR));

  a_r8_tdo_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ir != SEL_IR) && (ir != ACC_IR) |-> !tdo);

  a_r5_write_keeps_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_ack && bus_we |=> $stable(hold_q));
endmodule

// File: tb/scan_reg_bridge_tb.sv
module scan_reg_bridge_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [3:0]  ir = 4'hC;
  logic        capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic        tdo, bus_req, bus_we, bus_ack;
  logic [6:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  scan_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .ir(ir), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  localparam logic [31:0] ID_WORD = 32'h5A17_0C3E;

  logic [31:0] regs [128];
  int delay = 1, cnt = 0, nacc = 0, nwr = 0, npop = 0;
  logic [31:0] popv = 0;
  int total = 0, bad = 0;
  bit done = 0;

  initial begin
    bus_ack = 0;
    bus_rdata = 0;
    for (int i = 0; i < 128; i++) regs[i] = 32'h1000_0000 + i;
    regs[0] = ID_WORD;
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 0; cnt = 0;
    end else if (bus_ack) begin
      bus_ack = 0;
    end else if (bus_req) begin
      cnt++;
      if (cnt >= delay) begin
        cnt = 0; bus_ack = 1; nacc++;
        if (bus_we) begin
          nwr++; regs[bus_addr] = bus_wdata;
        end else if (bus_addr == 7'd4) begin
          bus_rdata = popv; popv++; npop++;
        end else begin
          bus_rdata = regs[bus_addr];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge clk); capture_dr = 1;
    @(negedge clk); capture_dr = 0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1; tdi = din[i]; dout[i] = tdo;
      @(negedge clk);
    end
    shift_dr = 0; tdi = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (bus_req) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [39:0] frame(input bit we, input logic [6:0] a, input logic [31:0] d);
    return {we, a, d};
  endfunction

  task automatic sel_chain(input logic [4:0] c);
    logic [39:0] d;
    ir = 4'h2;
    scan(5, {35'b0, c}, d);
    ir = 4'hC;
  endtask

  task automatic t_reset();
    logic [39:0] d;
    chk(bus_req == 0, "R1 no request after reset", bus_req, 0);
    scan(40, frame(0, 7'd0, 0), d);
    wait_idle();
    chk(d == 0, "R1 scan output zero after reset", d, 0);
    chk(nacc == 0, "R1 no access while chain invalid", nacc, 0);
  endtask

  task automatic t_write();
    logic [39:0] d;
    int w0 = nwr;
    sel_chain(5'd0);
    scan(40, frame(1, 7'd9, 32'h1234_5678), d);
    wait_idle();
    chk(regs[9] == 32'h1234_5678, "R3 write data at address 9", regs[9], 32'h1234_5678);
    chk(nwr == w0 + 1, "R3 one write per update", nwr, w0 + 1);
  endtask

  task automatic t_read_pipe();
    logic [39:0] d;
    scan(40, frame(0, 7'd9, 32'hFFFF_FFFF), d);
    wait_idle();
    scan(40, frame(1, 7'd10, 32'hCAFE_0010), d);
    wait_idle();
    chk(d[31:0] == 32'h1234_5678, "R4 read result on next scan", d[31:0], 32'h1234_5678);
    chk(d[39:32] == 0, "R4 upper bits zero", d[39:32], 0);
    scan(40, frame(0, 7'd0, 0), d);
    wait_idle();
    chk(d[31:0] == 32'h1234_5678, "R5 write left holding word", d[31:0], 32'h1234_5678);
    chk(regs[10] == 32'hCAFE_0010, "R3 write to address 10", regs[10], 32'hCAFE_0010);
    scan(40, frame(0, 7'd0, 0), d);
    wait_idle();
    chk(d[31:0] == ID_WORD, "R4 identification read", d[31:0], ID_WORD);
  endtask

  task automatic t_burst();
    logic [39:0] d;
    int n = 4;
    popv = 32'd100; npop = 0;
    scan(40, frame(0, 7'd4, 0), d);
    wait_idle();
    for (int i = 0; i < n; i++) begin
      scan(40, frame(0, (i < n - 1) ? 7'd4 : 7'd0, 0), d);
      wait_idle();
      chk(d[31:0] == 32'd100 + i, "R9 burst value", d[31:0], 32'd100 + i);
    end
    chk(npop == n, "R9 address 4 read count", npop, n);
  endtask

  task automatic t_other_chain();
    logic [39:0] d;
    int a0 = nacc;
    logic [31:0] old = regs[11];
    sel_chain(5'd16);
    scan(40, frame(1, 7'd11, 32'hDEAD_BEEF), d);
    wait_idle();
    chk(nacc == a0, "R2 chain 16 starts no access", nacc, a0);
    chk(regs[11] == old, "R2 chain 16 leaves register", regs[11], old);
    chk(d == 0, "R2 chain 16 output zero", d, 0);
    sel_chain(5'd0);
    scan(40, frame(1, 7'd11, 32'h0BAD_F00D), d);
    wait_idle();
    chk(regs[11] == 32'h0BAD_F00D, "R2 chain 0 restores access", regs[11], 32'h0BAD_F00D);
  endtask

  task automatic t_other_ir();
    logic [39:0] d;
    int a0 = nacc;
    ir = 4'h5;
    scan(40, frame(1, 7'd12, 32'h5555_AAAA), d);
    wait_idle();
    chk(d == 0, "R8 tdo zero under other instruction", d, 0);
    chk(nacc == a0, "R8 no access under other instruction", nacc, a0);
    ir = 4'hC;
  endtask

  task automatic t_busy();
    logic [39:0] d;
    int w0 = nwr;
    logic [31:0] old = regs[13];
    delay = 60;
    scan(40, frame(1, 7'd12, 32'hA1A1_A1A1), d);
    scan(40, frame(1, 7'd13, 32'hB2B2_B2B2), d);
    chk(bus_req == 1, "R6 request held while unacknowledged", bus_req, 1);
    wait_idle();
    chk(regs[12] == 32'hA1A1_A1A1, "R7 first write done", regs[12], 32'hA1A1_A1A1);
    chk(regs[13] == old, "R7 update while busy dropped", regs[13], old);
    chk(nwr == w0 + 1, "R7 single write", nwr, w0 + 1);
    delay = 1;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write();
    t_read_pipe();
    t_burst();
    t_other_chain();
    t_other_ir();
    t_busy();
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_up();
  end
endmodule